// File: doc/BRIEF.md
# Multiboot Fallback Boot Controller

This block decides which image a configuration engine fetches from serial flash each time configuration starts. A start is caused by a power-up reset, an external program pulse, an internal reprogram command, or an automatic retry after a failed load. The block holds two address registers, one for the multiboot image and one for the golden image. Each register carries a start address and a flash read opcode. For each start, the block drives the chosen address and opcode together with a one-cycle load-start pulse.

A load attempt is modelled as a request answered by a pass or a CRC-fail response. A built-in watchdog turns a missing response into a timeout error. Failures count as strikes. After three strikes the block falls back to the golden image, if reset-on-error is enabled. If the golden image also uses up its three strikes, the block halts. An internal reprogram keeps the stored addresses. A program pulse clears them and restarts from address 0. A packed status word reports the outcome of loading.

Top module: `mb_boot_ctrl`

## Requirements
- R1: While `rst_ni` is low, `status_o` is 0 and `load_start_o` is 0. On the first clock edge after release, `load_start_o` pulses with `fetch_addr_o` = 0 and `fetch_opc_o` = 8'h03.
- R2: A write with `wr_en_i` high goes to the multiboot register when `wr_sel_i`=0 and to the golden register when `wr_sel_i`=1. Data bits [23:0] are the start address and bits [31:24] are the read opcode.
- R3: In the running state, `iprog_i` starts a new load one cycle later from the stored multiboot address and opcode. The registers keep their contents.
- R4: A pass response sets `status_o[0]` (valid). Valid is cleared when a reprogram or retry begins a new load.
- R5: A CRC-fail response sets `status_o[3]` and adds one to the strike count in `status_o[6:4]`. The count only falls on a program pulse. When reset-on-error is on and no limit is reached, the same image is reloaded one cycle later.
- R6: If neither response arrives by the WDOG_CYCLES-th edge after the load-start edge, `status_o[2]` is set and the strike count rises at that edge.
- R7: The third strike with `rst_on_err_i` high sets `status_o[1]` (fallback). From then on, every load fetches the golden address and opcode until a program pulse.
- R8: With `rst_on_err_i` low, any load error halts the controller at once (`status_o[7]`) with no retry.
- R9: A sixth strike, taken while in fallback, halts the controller. The status word is then held, no further load starts, and `iprog_i` is ignored.
- R10: `prog_pulse_i` clears the status and both registers (address 0, opcode 8'h03). A load from address 0 begins on the next edge.
- R11: `load_start_o` is high for exactly one cycle per load. Responses that arrive while no load is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| prog_pulse_i | input | 1 | External program pulse |
| iprog_i | input | 1 | Internal reprogram command |
| rst_on_err_i | input | 1 | Enables retry and fallback on load errors |
| wr_en_i | input | 1 | Address register write strobe |
| wr_sel_i | input | 1 | 0 selects multiboot, 1 selects golden |
| wr_data_i | input | 32 | {opcode[7:0], address[23:0]} |
| load_pass_i | input | 1 | Load attempt succeeded |
| load_crc_err_i | input | 1 | Load attempt failed its CRC |
| load_start_o | output | 1 | One-cycle load request |
| fetch_addr_o | output | 24 | Flash start address of this load |
| fetch_opc_o | output | 8 | Flash read opcode of this load |
| status_o | output | 8 | {halted, strikes[2:0], crc_err, wto_err, fallback, valid} |

## Verification
Most results are registered at the clock edge that samples the stimulus. Valid, the error bits, the strike count, fallback and halt can therefore be read just after that edge. The load-start pulse that follows a trigger or a retry appears one edge later, because the controller passes through a single kick state. A timeout is due exactly WDOG_CYCLES edges after the load-start edge. The bench drives inputs on falling edges and samples one nanosecond after each rising edge. It checks the cycle before the timeout is due as well as the timeout cycle itself.

// File: rtl/mb_boot_pkg.sv
`timescale 1ns/1ps
package mb_boot_pkg;
  typedef enum logic [1:0] {
    ST_KICK = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_HALT = 2'd3
  } boot_state_e;

  localparam int STAT_VALID = 0;
  localparam int STAT_FB    = 1;
  localparam int STAT_WTO   = 2;
  localparam int STAT_CRC   = 3;
  localparam int STAT_STK   = 4;
endpackage

// File: rtl/mb_addr_regs.sv
`timescale 1ns/1ps
module mb_addr_regs #(
  parameter int ADDR_W = 24,
  parameter int OPC_W = 8,
  parameter logic [7:0] DEF_OPC = 8'h03,
  localparam int WORD_W = ADDR_W + OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] mb_addr_o,
  output logic [OPC_W-1:0]  mb_opc_o,
  output logic [ADDR_W-1:0] gd_addr_o,
  output logic [OPC_W-1:0]  gd_opc_o
);
  localparam logic [WORD_W-1:0] RST_WORD = {OPC_W'(DEF_OPC), {ADDR_W{1'b0}}};

  logic [WORD_W-1:0] word_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q[g] <= RST_WORD;
      else if (clr_i)                               word_q[g] <= RST_WORD;
      else if (wr_en_i && (wr_sel_i == 1'(g)))      word_q[g] <= wr_data_i;
    end
  end

  assign mb_addr_o = word_q[0][ADDR_W-1:0];
  assign mb_opc_o  = word_q[0][WORD_W-1:ADDR_W];
  assign gd_addr_o = word_q[1][ADDR_W-1:0];
  assign gd_opc_o  = word_q[1][WORD_W-1:ADDR_W];
endmodule

// File: rtl/mb_load_wdog.sv
`timescale 1ns/1ps
module mb_load_wdog #(
  parameter int CYCLES = 64,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (!expire_o)   cnt_q <= cnt_q + 1'b1;
  end

  // cnt_q equals k-1 at the k-th edge spent waiting
  assign expire_o = run_i && (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/mb_boot_ctrl.sv
`timescale 1ns/1ps
module mb_boot_ctrl
  import mb_boot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OPC_W = 8,
  parameter logic [7:0] DEF_OPC = 8'h03,
  parameter int WDOG_CYCLES = 64,
  parameter int STRIKES = 3,
  localparam int SW = $clog2(2 * STRIKES + 1),
  localparam int STAT_W = SW + 5,
  localparam int WORD_W = ADDR_W + OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_pulse_i,
  input  logic              iprog_i,
  input  logic              rst_on_err_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              load_pass_i,
  input  logic              load_crc_err_i,
  output logic              load_start_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [OPC_W-1:0]  fetch_opc_o,
  output logic [STAT_W-1:0] status_o
);
  boot_state_e     state_q;
  logic            use_mb_q, fb_q, crc_q, wto_q, valid_q;
  logic [SW-1:0]   strikes_q, strike_nx;
  logic [ADDR_W-1:0] mb_addr, gd_addr;
  logic [OPC_W-1:0]  mb_opc, gd_opc;
  logic            wd_expire, load_err;

  mb_addr_regs #(
    .ADDR_W (ADDR_W),
    .OPC_W  (OPC_W),
    .DEF_OPC(DEF_OPC)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (prog_pulse_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .mb_addr_o(mb_addr),
    .mb_opc_o (mb_opc),
    .gd_addr_o(gd_addr),
    .gd_opc_o (gd_opc)
  );

  mb_load_wdog #(.CYCLES(WDOG_CYCLES)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_WAIT),
    .expire_o(wd_expire)
  );

  assign strike_nx = strikes_q + 1'b1;
  assign load_err  = !load_pass_i && (load_crc_err_i || wd_expire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_KICK;
      use_mb_q     <= 1'b0;
      fb_q         <= 1'b0;
      crc_q        <= 1'b0;
      wto_q        <= 1'b0;
      valid_q      <= 1'b0;
      strikes_q    <= '0;
      load_start_o <= 1'b0;
      fetch_addr_o <= '0;
      fetch_opc_o  <= OPC_W'(DEF_OPC);
    end else begin
      load_start_o <= 1'b0;
      if (prog_pulse_i) begin
        state_q   <= ST_KICK;
        use_mb_q  <= 1'b0;
        fb_q      <= 1'b0;
        crc_q     <= 1'b0;
        wto_q     <= 1'b0;
        valid_q   <= 1'b0;
        strikes_q <= '0;
      end else begin
        unique case (state_q)
          ST_KICK: begin
            state_q      <= ST_WAIT;
            load_start_o <= 1'b1;
            valid_q      <= 1'b0;
            if (fb_q) begin
              fetch_addr_o <= gd_addr;
              fetch_opc_o  <= gd_opc;
            end else if (use_mb_q) begin
              fetch_addr_o <= mb_addr;
              fetch_opc_o  <= mb_opc;
            end else begin
              fetch_addr_o <= '0;
              fetch_opc_o  <= OPC_W'(DEF_OPC);
            end
          end
          ST_WAIT: begin
            if (load_pass_i) begin
              state_q <= ST_RUN;
              valid_q <= 1'b1;
            end else if (load_err) begin
              strikes_q <= strike_nx;
              if (load_crc_err_i) crc_q <= 1'b1;
              else                wto_q <= 1'b1;
              if (!rst_on_err_i) begin
                state_q <= ST_HALT;
              end else if (!fb_q && strike_nx == SW'(STRIKES)) begin
                fb_q    <= 1'b1;
                state_q <= ST_KICK;
              end else if (strike_nx >= SW'(2 * STRIKES)) begin
                state_q <= ST_HALT;
              end else begin
                state_q <= ST_KICK;
              end
            end
          end
          ST_RUN: begin
            if (iprog_i) begin
              state_q  <= ST_KICK;
              use_mb_q <= 1'b1;
              valid_q  <= 1'b0;
            end
          end
          default: state_q <= ST_HALT;
        endcase
      end
    end
  end

  assign status_o = {state_q == ST_HALT, strikes_q, crc_q, wto_q, fb_q, valid_q};
endmodule

// File: rtl/mb_boot_chk.sv
`timescale 1ns/1ps
module mb_boot_chk #(
  parameter int ADDR_W = 24,
  parameter int STAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_pulse_i,
  input logic              load_start_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [ADDR_W-1:0] gd_addr,
  input logic [STAT_W-1:0] status_o
);
  localparam int HB = STAT_W - 1;
  localparam int SW = STAT_W - 5;

  logic [SW-1:0] stk;
  assign stk = status_o[HB-1:4];

  // R11
  load_start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_start_o |=> !load_start_o);

  // R7
  golden_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_start_o && status_o[1]) |-> fetch_addr_o == $past(gd_addr));

  // R10
  fallback_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[1]) |-> $past(prog_pulse_i));

  // R5
  strike_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk < $past(stk)) |-> $past(prog_pulse_i));

  // R9
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[HB] && !prog_pulse_i) |=> ($stable(status_o) && !load_start_o));

  // R8
  halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[HB] |-> (status_o[2] || status_o[3]));
endmodule

bind mb_boot_ctrl mb_boot_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_pulse_i(prog_pulse_i),
  .load_start_o(load_start_o),
  .fetch_addr_o(fetch_addr_o),
  .gd_addr     (gd_addr),
  .status_o    (status_o)
);

// File: tb/mb_boot_ctrl_tb.sv
`timescale 1ns/1ps
module mb_boot_ctrl_tb;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic prog_pulse_i = 1'b0, iprog_i = 1'b0, rst_on_err_i = 1'b1;
  logic wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic load_pass_i = 1'b0, load_crc_err_i = 1'b0;
  logic load_start_o;
  logic [23:0] fetch_addr_o;
  logic [7:0] fetch_opc_o;
  logic [7:0] status_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mb_boot_ctrl #(.WDOG_CYCLES(W)) u_dut (.*);

  function automatic logic [7:0] st(bit v, bit fb, bit wto, bit crc, int stk, bit halt);
    return {halt, 3'(stk), crc, wto, fb, v};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic drive(bit pass, bit crc, bit ip, bit pg);
    @(negedge clk_i);
    load_pass_i = pass; load_crc_err_i = crc; iprog_i = ip; prog_pulse_i = pg;
    wr_en_i = 1'b0;
    @(posedge clk_i); #1;
  endtask

  task automatic idle(); drive(0, 0, 0, 0); endtask

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk_i);
    load_pass_i = 0; load_crc_err_i = 0; iprog_i = 0; prog_pulse_i = 0;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    #5;
    chk("R1 status in reset", status_o, 0);
    chk("R1 no start in reset", load_start_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 start after reset", load_start_o, 1);
    chk("R1 addr 0", fetch_addr_o, 0);
    chk("R1 opcode", fetch_opc_o, 8'h03);
  endtask

  task automatic t_pass_and_ignore();
    drive(1, 0, 0, 0);
    chk("R4 valid set", status_o, st(1, 0, 0, 0, 0, 0));
    chk("R11 single pulse", load_start_o, 0);
    drive(0, 1, 0, 0);
    chk("R11 crc ignored when running", status_o, st(1, 0, 0, 0, 0, 0));
    idle();
    chk("R11 no spurious start", load_start_o, 0);
  endtask

  task automatic t_iprog();
    wr(0, {8'h0B, 24'h200000});
    wr(1, {8'h03, 24'h010000});
    drive(0, 0, 1, 0);
    chk("R4 valid cleared on reprogram", status_o, st(0, 0, 0, 0, 0, 0));
    chk("R3 start one cycle later", load_start_o, 0);
    idle();
    chk("R3 start", load_start_o, 1);
    chk("R2 R3 mb addr", fetch_addr_o, 24'h200000);
    chk("R2 R3 mb opcode", fetch_opc_o, 8'h0B);
  endtask

  task automatic t_strikes();
    drive(0, 1, 0, 0);
    chk("R5 crc strike", status_o, st(0, 0, 0, 1, 1, 0));
    idle();
    chk("R5 retry start", load_start_o, 1);
    chk("R5 retry addr", fetch_addr_o, 24'h200000);
    for (int i = 0; i < W - 1; i++) idle();
    chk("R6 no timeout early", status_o, st(0, 0, 0, 1, 1, 0));
    idle();
    chk("R6 timeout", status_o, st(0, 0, 1, 1, 2, 0));
    idle();
    chk("R6 retry addr", fetch_addr_o, 24'h200000);
    drive(0, 1, 0, 0);
    chk("R7 fallback", status_o, st(0, 1, 1, 1, 3, 0));
    idle();
    chk("R7 golden start", load_start_o, 1);
    chk("R7 golden addr", fetch_addr_o, 24'h010000);
    chk("R7 golden opcode", fetch_opc_o, 8'h03);
    drive(1, 0, 0, 0);
    chk("R4 valid on golden", status_o, st(1, 1, 1, 1, 3, 0));
    drive(0, 0, 1, 0);
    idle();
    chk("R7 reprogram stays golden", fetch_addr_o, 24'h010000);
  endtask

  task automatic t_halt();
    drive(0, 1, 0, 0);
    idle();
    drive(0, 1, 0, 0);
    idle();
    drive(0, 1, 0, 0);
    chk("R9 halted", status_o, st(0, 1, 1, 1, 6, 1));
    for (int i = 0; i < 4; i++) begin
      idle();
      chk("R9 no start when halted", load_start_o, 0);
    end
    drive(0, 0, 1, 0);
    idle();
    chk("R9 iprog ignored", status_o, st(0, 1, 1, 1, 6, 1));
    chk("R9 iprog no start", load_start_o, 0);
  endtask

  task automatic t_prog();
    drive(0, 0, 0, 1);
    chk("R10 status cleared", status_o, 0);
    idle();
    chk("R10 start", load_start_o, 1);
    chk("R10 addr 0", fetch_addr_o, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 0);
    idle();
    chk("R10 mb addr cleared", fetch_addr_o, 0);
    chk("R10 mb opcode default", fetch_opc_o, 8'h03);
  endtask

  task automatic t_no_reset_on_err();
    rst_on_err_i = 1'b0;
    drive(0, 1, 0, 0);
    chk("R8 halt on error", status_o, st(0, 0, 0, 1, 1, 1));
    idle();
    chk("R8 no retry", load_start_o, 0);
    rst_on_err_i = 1'b1;
    drive(0, 0, 0, 1);
    idle();
    chk("R10 restart after halt", load_start_o, 1);
  endtask

  initial begin
    t_reset();
    t_pass_and_ignore();
    t_iprog();
    t_strikes();
    t_halt();
    t_prog();
    t_no_reset_on_err();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule